// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a multi-function peripheral controller. It watches a byte-wide I/O bus at two addresses: a base port, chosen by a strap input, and the address one above it. In normal operation the register file is locked. Software opens it by writing an unlock byte to the base port twice in a row, and closes it again with a single lock byte.

While the block is open, a write to the base port selects a register index. A read or write at base+1 then reaches that register. A few indices are global: the device number, a constant identifier, a revision byte and a read-only map of device enables. The other indices reach a bank of registers that belongs to the logical device chosen by the device-number register. Each bank drives its activate bit, a 16-bit I/O base and an interrupt select straight out of the block. Some banks also have a secondary interrupt, a DMA channel or floppy mode and option bytes. The peripherals themselves are not part of this block.

The lock logic is a three-state machine:
- `LK_LOCKED` goes to `LK_ONE_KEY` on a base-port write of 0x55.
- `LK_ONE_KEY` goes to `LK_OPEN` on a second base-port write of 0x55. Any other base-port write sends it back to `LK_LOCKED`.
- `LK_OPEN` goes to `LK_LOCKED` on a base-port write of 0xAA. Any other base-port write loads the index.

Writes to other addresses never move the machine.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The block opens only after two base-port writes of 0x55 in a row. Any other byte written to the base port while locked restarts the count. Writes to other addresses do not break the pair.
- R2: A base-port write of 0xAA while open returns the block to the locked state. Data-port accesses after that behave as in R11.
- R3: With `base_sel`=0 the base port is 0x3F0; with `base_sel`=1 it is 0x370. The data port is base+1. Accesses to any other address have no effect, and reads there return 0x00.
- R4: While open, a base-port write other than 0xAA loads the 8-bit index. A data-port write updates the indexed register. A data-port read returns the indexed register on `bus_rdata` in the same cycle that `bus_rd` is high. At all other times `bus_rdata` is 0x00.
- R5: Index 0x20 reads 0x02 and index 0x21 reads the revision parameter (default 0x01). Both are read-only.
- R6: Index 0x07 is the read/write device-number register. The numbers are: floppy 0, IDE1 1, IDE2 2, parallel 3, serial1 4, serial2 5, RTC 6, keyboard 7, aux 8.
- R7: Each of devices 0 to 8 has its own copies of these registers:
  - index 0x30: activate. Only bit 0 is stored, and it reads back as {7'b0, bit0}.
  - index 0x60: I/O base high byte.
  - index 0x61: I/O base low byte.
  - index 0x70: interrupt select.

  These drive `dev_active[d]`, `dev_iobase[16d+15:16d]` = {high, low} and `dev_irq[8d+7:8d]`.
- R8: Index 0x72 (secondary interrupt) exists only for device 7. Index 0x74 (DMA) exists only for devices 0 and 3. Indices 0x90 (mode) and 0x91 (option) exist only for device 0. They drive `dev_irq2`, `dev_dma`, `dev_mode` and `dev_option` in the 8d slice. For a device that lacks one of these registers, its index reads 0x00, a write to it is ignored, and its output slice stays 0.
- R9: Index 0x22 reads the activate bits of devices 0 to 5 in bits 5:0, with bits 7:6 at zero. It is read-only.
- R10: Indices not listed in R5 to R9 read 0x00, and writes to them are ignored. While the device number is 9 or higher, per-device indices read 0x00 and writes to them are ignored.
- R11: While locked, data-port reads return 0x00 and data-port writes change no register.
- R12: After reset the block is locked, the index and the device number are 0, and every device register is 0, so all devices are deactivated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Strap: 0 selects base 0x3F0, 1 selects base 0x370 |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0x00 unless a data-port read is served |
| dev_active | output | 9 | Activate bit per device |
| dev_iobase | output | 144 | 16-bit I/O base per device |
| dev_irq | output | 72 | Interrupt select per device |
| dev_irq2 | output | 72 | Secondary interrupt per device (device 7 only) |
| dev_dma | output | 72 | DMA select per device (devices 0 and 3 only) |
| dev_mode | output | 72 | Mode byte per device (device 0 only) |
| dev_option | output | 72 | Option byte per device (device 0 only) |

## Verification
The unlock machine is driven with these base-port patterns:
- a clean 0x55 pair;
- a pair broken by another byte at the base port;
- a pair with a data-port write between the two keys;
- a pair aimed at the unselected base.

These separate the correct count reset from a reset on any bus write, and a decoder that ignores the strap. Register traffic sweeps every device number from 0 to 10 against every implemented index plus random ones. Seeded random mixes of index loads, data writes, reads and lock/unlock keys then run under both straps. This tells apart per-device banking, capability gating (0x72, 0x74, 0x90 and 0x91 on the wrong device) and the enable map at 0x22. Data-port writes made while locked are read back after reopening, which shows whether the lock really blocks writes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // key bytes seen at the base port
    localparam byte_t KEY_OPEN  = 8'h55;
    localparam byte_t KEY_CLOSE = 8'hAA;

    // global indices
    localparam byte_t IX_DEVNUM = 8'h07;
    localparam byte_t IX_ID     = 8'h20;
    localparam byte_t IX_REV    = 8'h21;
    localparam byte_t IX_ENMAP  = 8'h22;

    // per-device indices
    localparam byte_t IX_ACT    = 8'h30;
    localparam byte_t IX_IOHI   = 8'h60;
    localparam byte_t IX_IOLO   = 8'h61;
    localparam byte_t IX_IRQ    = 8'h70;
    localparam byte_t IX_IRQ2   = 8'h72;
    localparam byte_t IX_DMA    = 8'h74;
    localparam byte_t IX_FMODE  = 8'h90;
    localparam byte_t IX_FOPT   = 8'h91;

    localparam byte_t ID_VALUE  = 8'h02;

    // device numbers that carry optional registers
    localparam int DEV_FLOPPY   = 0;
    localparam int DEV_PARALLEL = 3;
    localparam int DEV_KEYBOARD = 7;

    // devices reflected in the enable map
    localparam int ENMAP_DEVS   = 6;

    typedef enum logic [1:0] {
        LK_LOCKED  = 2'd0,
        LK_ONE_KEY = 2'd1,
        LK_OPEN    = 2'd2
    } lock_state_e;

endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  port_wr,
    input  byte_t port_wdata,
    output logic  cfg_open,
    output logic  index_load
);

    lock_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: begin
                if (port_wr && port_wdata == KEY_OPEN) begin
                    state_d = LK_ONE_KEY;
                end
            end
            LK_ONE_KEY: begin
                if (port_wr) begin
                    state_d = (port_wdata == KEY_OPEN) ? LK_OPEN : LK_LOCKED;
                end
            end
            LK_OPEN: begin
                if (port_wr && port_wdata == KEY_CLOSE) begin
                    state_d = LK_LOCKED;
                end
            end
            default: state_d = LK_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        cfg_open   = (state_q == LK_OPEN);
        index_load = (state_q == LK_OPEN) && port_wr && (port_wdata != KEY_CLOSE);
    end

    assert_open_needs_key_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && $past(state_q) != LK_OPEN) |->
            ($past(state_q) == LK_ONE_KEY && $past(port_wr) && $past(port_wdata) == KEY_OPEN));

    assert_stray_byte_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ONE_KEY && port_wr && port_wdata != KEY_OPEN) |=> state_q == LK_LOCKED);

    assert_close_key_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && port_wr && port_wdata == KEY_CLOSE) |=> !cfg_open);

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_pkg::*;
#(
    parameter bit HAS_IRQ2 = 1'b0,
    parameter bit HAS_DMA  = 1'b0,
    parameter bit HAS_FDD  = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  byte_t               idx,
    input  byte_t               wdata,
    output byte_t               rdata,
    output logic                active,
    output logic [2*BYTE_W-1:0] iobase,
    output byte_t               irq,
    output byte_t               irq2,
    output byte_t               dma,
    output byte_t               fmode,
    output byte_t               fopt
);

    logic  act_q;
    byte_t hi_q, lo_q, irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            hi_q  <= '0;
            lo_q  <= '0;
            irq_q <= '0;
        end else if (wr_en) begin
            case (idx)
                IX_ACT:  act_q <= wdata[0];
                IX_IOHI: hi_q  <= wdata;
                IX_IOLO: lo_q  <= wdata;
                IX_IRQ:  irq_q <= wdata;
                default: ;
            endcase
        end
    end

    generate
        if (HAS_IRQ2) begin : g_irq2
            byte_t q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      q <= '0;
                else if (wr_en && idx == IX_IRQ2) q <= wdata;
            end
            assign irq2 = q;
        end else begin : g_no_irq2
            assign irq2 = '0;
        end

        if (HAS_DMA) begin : g_dma
            byte_t q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                     q <= '0;
                else if (wr_en && idx == IX_DMA) q <= wdata;
            end
            assign dma = q;
        end else begin : g_no_dma
            assign dma = '0;
        end

        if (HAS_FDD) begin : g_fdd
            byte_t mode_q, opt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mode_q <= '0;
                    opt_q  <= '0;
                end else if (wr_en) begin
                    if (idx == IX_FMODE) mode_q <= wdata;
                    if (idx == IX_FOPT)  opt_q  <= wdata;
                end
            end
            assign fmode = mode_q;
            assign fopt  = opt_q;
        end else begin : g_no_fdd
            assign fmode = '0;
            assign fopt  = '0;
        end
    endgenerate

    assign active = act_q;
    assign iobase = {hi_q, lo_q};
    assign irq    = irq_q;

    // read selection; absent registers are tied to zero above
    always_comb begin
        case (idx)
            IX_ACT:   rdata = {{(BYTE_W-1){1'b0}}, act_q};
            IX_IOHI:  rdata = hi_q;
            IX_IOLO:  rdata = lo_q;
            IX_IRQ:   rdata = irq_q;
            IX_IRQ2:  rdata = irq2;
            IX_DMA:   rdata = dma;
            IX_FMODE: rdata = fmode;
            IX_FOPT:  rdata = fopt;
            default:  rdata = '0;
        endcase
    end

    assert_activate_takes_bit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_ACT) |=> active == $past(wdata[0]));

    assert_low_byte_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_IOLO) |=>
            (iobase[BYTE_W-1:0] == $past(wdata) && iobase[2*BYTE_W-1:BYTE_W] == $past(iobase[2*BYTE_W-1:BYTE_W])));

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                NDEV      = 9,
    parameter logic [ADDR_W-1:0] BASE_PRI  = 16'h03F0,
    parameter logic [ADDR_W-1:0] BASE_ALT  = 16'h0370,
    parameter logic [7:0]        REV_VALUE = 8'h01
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     base_sel,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    output logic [NDEV-1:0]          dev_active,
    output logic [NDEV*2*BYTE_W-1:0] dev_iobase,
    output logic [NDEV*BYTE_W-1:0]   dev_irq,
    output logic [NDEV*BYTE_W-1:0]   dev_irq2,
    output logic [NDEV*BYTE_W-1:0]   dev_dma,
    output logic [NDEV*BYTE_W-1:0]   dev_mode,
    output logic [NDEV*BYTE_W-1:0]   dev_option
);

    localparam int                IO_W    = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam byte_t             NDEV_B  = byte_t'(NDEV);

    logic [ADDR_W-1:0] base_addr, data_addr;
    logic  hit_base, hit_data;
    logic  port_wr, data_wr, data_rd;
    logic  cfg_open, index_load;
    byte_t idx_q, devnum_q;
    logic  dev_ok;
    byte_t enmap, glob_rd, dev_rd;
    byte_t bank_rd [NDEV];

    // address decode
    always_comb begin
        base_addr = base_sel ? BASE_ALT : BASE_PRI;
        data_addr = base_addr + ADDR_ONE;
        hit_base  = (bus_addr == base_addr);
        hit_data  = (bus_addr == data_addr);
        port_wr   = bus_wr && hit_base;
        data_wr   = bus_wr && hit_data && cfg_open;
        data_rd   = bus_rd && hit_data && cfg_open;
        dev_ok    = (devnum_q < NDEV_B);
    end

    cfg_lock_fsm u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_wr    (port_wr),
        .port_wdata (bus_wdata),
        .cfg_open   (cfg_open),
        .index_load (index_load)
    );

    // index and device-number registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            devnum_q <= '0;
        end else begin
            if (index_load)                       idx_q    <= bus_wdata;
            if (data_wr && idx_q == IX_DEVNUM)    devnum_q <= bus_wdata;
        end
    end

    // per-device banks
    generate
        for (genvar d = 0; d < NDEV; d++) begin : g_dev
            localparam bit D_IRQ2 = (d == DEV_KEYBOARD);
            localparam bit D_DMA  = (d == DEV_FLOPPY) || (d == DEV_PARALLEL);
            localparam bit D_FDD  = (d == DEV_FLOPPY);
            logic we;
            assign we = data_wr && (devnum_q == byte_t'(d));
            cfg_dev_bank #(
                .HAS_IRQ2 (D_IRQ2),
                .HAS_DMA  (D_DMA),
                .HAS_FDD  (D_FDD)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (we),
                .idx    (idx_q),
                .wdata  (bus_wdata),
                .rdata  (bank_rd[d]),
                .active (dev_active[d]),
                .iobase (dev_iobase[d*IO_W +: IO_W]),
                .irq    (dev_irq[d*BYTE_W +: BYTE_W]),
                .irq2   (dev_irq2[d*BYTE_W +: BYTE_W]),
                .dma    (dev_dma[d*BYTE_W +: BYTE_W]),
                .fmode  (dev_mode[d*BYTE_W +: BYTE_W]),
                .fopt   (dev_option[d*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    // enable map and read mux
    always_comb begin
        enmap = '0;
        for (int i = 0; i < ENMAP_DEVS; i++) begin
            if (i < NDEV) enmap[i] = dev_active[i];
        end
        dev_rd = '0;
        for (int d = 0; d < NDEV; d++) begin
            if (devnum_q == byte_t'(d)) dev_rd = bank_rd[d];
        end
        case (idx_q)
            IX_DEVNUM: glob_rd = devnum_q;
            IX_ID:     glob_rd = ID_VALUE;
            IX_REV:    glob_rd = REV_VALUE;
            IX_ENMAP:  glob_rd = enmap;
            default:   glob_rd = dev_rd;
        endcase
        bus_rdata = data_rd ? glob_rd : '0;
    end

    assert_index_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && hit_base && bus_wdata != KEY_CLOSE) |=> idx_q == $past(bus_wdata));

    assert_locked_write_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_wr && hit_data) |=>
            ($stable(devnum_q) && $stable(dev_active) && $stable(dev_iobase) && $stable(dev_irq)));

    assert_bad_device_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !dev_ok && idx_q != IX_DEVNUM) |=>
            ($stable(dev_active) && $stable(dev_iobase) && $stable(dev_irq) && $stable(dev_dma)));

endmodule

// File: tb/test_cfg_port_ctrl.sv
`timescale 1ns/1ps
module test_cfg_port_ctrl;

    localparam int NDEV = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_sel = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [NDEV-1:0]    dev_active;
    logic [NDEV*16-1:0] dev_iobase;
    logic [NDEV*8-1:0]  dev_irq, dev_irq2, dev_dma, dev_mode, dev_option;

    always #4 clk = ~clk;

    cfg_port_ctrl i_cfg_port_ctrl (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_active(dev_active), .dev_iobase(dev_iobase), .dev_irq(dev_irq),
        .dev_irq2(dev_irq2), .dev_dma(dev_dma), .dev_mode(dev_mode), .dev_option(dev_option)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    int         m_state;
    logic [7:0] m_idx, m_dev;
    logic       m_act [NDEV];
    logic [7:0] m_hi [NDEV], m_lo [NDEV], m_irq [NDEV], m_irq2 [NDEV];
    logic [7:0] m_dma [NDEV], m_mode [NDEV], m_opt [NDEV];

    function automatic logic [15:0] base_of();
        return base_sel ? 16'h0370 : 16'h03F0;
    endfunction

    task automatic model_reset();
        m_state = 0; m_idx = '0; m_dev = '0;
        for (int d = 0; d < NDEV; d++) begin
            m_act[d] = 1'b0; m_hi[d] = '0; m_lo[d] = '0; m_irq[d] = '0;
            m_irq2[d] = '0; m_dma[d] = '0; m_mode[d] = '0; m_opt[d] = '0;
        end
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] v);
        int d;
        if (a == base_of()) begin
            case (m_state)
                0: m_state = (v == 8'h55) ? 1 : 0;
                1: m_state = (v == 8'h55) ? 2 : 0;
                default: if (v == 8'hAA) m_state = 0; else m_idx = v;
            endcase
        end else if (a == base_of() + 16'd1 && m_state == 2) begin
            if (m_idx == 8'h07) m_dev = v;
            else if (m_dev < 8'(NDEV)) begin
                d = int'(m_dev);
                case (m_idx)
                    8'h30: m_act[d] = v[0];
                    8'h60: m_hi[d] = v;
                    8'h61: m_lo[d] = v;
                    8'h70: m_irq[d] = v;
                    8'h72: if (d == 7) m_irq2[d] = v;
                    8'h74: if (d == 0 || d == 3) m_dma[d] = v;
                    8'h90: if (d == 0) m_mode[d] = v;
                    8'h91: if (d == 0) m_opt[d] = v;
                    default: ;
                endcase
            end
        end
    endtask

    function automatic logic [7:0] model_read(input logic [15:0] a);
        int d;
        logic [7:0] r;
        r = '0;
        if (a == base_of() + 16'd1 && m_state == 2) begin
            case (m_idx)
                8'h07: r = m_dev;
                8'h20: r = 8'h02;
                8'h21: r = 8'h01;
                8'h22: for (int i = 0; i < 6; i++) r[i] = m_act[i];
                default: if (m_dev < 8'(NDEV)) begin
                    d = int'(m_dev);
                    case (m_idx)
                        8'h30: r = {7'b0, m_act[d]};
                        8'h60: r = m_hi[d];
                        8'h61: r = m_lo[d];
                        8'h70: r = m_irq[d];
                        8'h72: r = m_irq2[d];
                        8'h74: r = m_dma[d];
                        8'h90: r = m_mode[d];
                        8'h91: r = m_opt[d];
                        default: r = '0;
                    endcase
                end
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of();
        if (m_state != 2) return "R11";
        case (m_idx)
            8'h07: return "R6";
            8'h20, 8'h21: return "R5";
            8'h22: return "R9";
            8'h30, 8'h60, 8'h61, 8'h70: return (m_dev < 8'(NDEV)) ? "R7" : "R10";
            8'h72, 8'h74, 8'h90, 8'h91: return (m_dev < 8'(NDEV)) ? "R8" : "R10";
            default: return "R10";
        endcase
    endfunction

    task automatic check_val(input string req, input logic [143:0] got, input logic [143:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // bus access
    task automatic do_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, v);
    endtask

    task automatic do_read(input logic [15:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        check_val(req, 144'(bus_rdata), 144'(model_read(a)));
        bus_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] ix, input logic [7:0] v);
        do_write(base_of(), ix);
        do_write(base_of() + 16'd1, v);
    endtask

    task automatic reg_read(input logic [7:0] ix, input string req);
        do_write(base_of(), ix);
        do_read(base_of() + 16'd1, req);
    endtask

    task automatic unlock();
        do_write(base_of(), 8'h55);
        do_write(base_of(), 8'h55);
    endtask

    task automatic check_outputs(input string req);
        logic [NDEV-1:0]    ea;
        logic [NDEV*16-1:0] eio;
        logic [NDEV*8-1:0]  eirq, eirq2, edma, emode, eopt;
        for (int d = 0; d < NDEV; d++) begin
            ea[d] = m_act[d];
            eio[d*16 +: 16] = {m_hi[d], m_lo[d]};
            eirq[d*8 +: 8]  = m_irq[d];
            eirq2[d*8 +: 8] = m_irq2[d];
            edma[d*8 +: 8]  = m_dma[d];
            emode[d*8 +: 8] = m_mode[d];
            eopt[d*8 +: 8]  = m_opt[d];
        end
        @(negedge clk);
        check_val({req, " active"}, 144'(dev_active), 144'(ea));
        check_val({req, " iobase"}, 144'(dev_iobase), 144'(eio));
        check_val({req, " irq"},    144'(dev_irq),    144'(eirq));
        check_val({req, " irq2"},   144'(dev_irq2),   144'(eirq2));
        check_val({req, " dma"},    144'(dev_dma),    144'(edma));
        check_val({req, " mode"},   144'(dev_mode),   144'(emode));
        check_val({req, " option"}, 144'(dev_option), 144'(eopt));
    endtask

    task automatic apply_reset(input logic sel);
        rst_n = 1'b0;
        base_sel = sel;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] pick_idx();
        case ($urandom % 14)
            0: return 8'h07;  1: return 8'h20;  2: return 8'h21;  3: return 8'h22;
            4: return 8'h30;  5: return 8'h60;  6: return 8'h61;  7: return 8'h70;
            8: return 8'h72;  9: return 8'h74;  10: return 8'h90; 11: return 8'h91;
            12: return 8'h07;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic random_phase(input int ops);
        for (int k = 0; k < ops; k++) begin
            case ($urandom % 11)
                0, 1: begin
                    case ($urandom % 4)
                        0: do_write(base_of(), 8'h55);
                        1: do_write(base_of(), 8'hAA);
                        default: do_write(base_of(), pick_idx());
                    endcase
                end
                2, 3, 4: begin
                    if (m_idx == 8'h07) do_write(base_of() + 16'd1, 8'($urandom % 11));
                    else                do_write(base_of() + 16'd1, 8'($urandom));
                end
                5, 6, 7: do_read(base_of() + 16'd1, tag_of());
                8: begin
                    do_write(base_of() ^ 16'h0100, 8'h55);
                    do_read(base_of() ^ 16'h0101, "R3");
                end
                9: check_outputs("R7/R8 random");
                default: if (m_state != 2) unlock();
            endcase
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd24681));
        apply_reset(1'b0);

        // R12: reset state
        check_outputs("R12 reset");
        do_read(16'h03F1, "R12 locked after reset");
        unlock();
        do_read(16'h03F1, "R12 index zero");
        reg_read(8'h07, "R12 device number zero");
        do_write(16'h03F0, 8'hAA);

        // R1: broken pair does not open
        do_write(16'h03F0, 8'h55);
        do_write(16'h03F0, 8'h20);
        do_write(16'h03F0, 8'h55);
        do_read(16'h03F1, "R1 broken pair stays locked");
        // R1: data-port write between keys does not break the pair
        do_write(16'h03F1, 8'h11);
        do_write(16'h03F0, 8'h55);
        reg_read(8'h20, "R1 pair across other address opens");
        reg_read(8'h21, "R5 revision");
        reg_write(8'h20, 8'h77);
        reg_read(8'h20, "R5 identifier read-only");

        // R2: lock key
        do_write(16'h03F0, 8'hAA);
        do_read(16'h03F1, "R2 locked after close key");

        // R3: unselected base ignored
        do_write(16'h0370, 8'h55);
        do_write(16'h0370, 8'h55);
        do_read(16'h0371, "R3 alternate base inactive");
        do_read(16'h03F1, "R3 still locked");

        // R6/R7/R8: program every device
        unlock();
        for (int d = 0; d < NDEV; d++) begin
            reg_write(8'h07, 8'(d));
            reg_read(8'h07, "R6 device number");
            reg_write(8'h30, 8'hF0 | 8'(d & 1));
            reg_write(8'h60, 8'(d + 8'h10));
            reg_write(8'h61, 8'(8'hA0 + d));
            reg_write(8'h70, 8'(d + 1));
            reg_write(8'h72, 8'(8'h40 + d));
            reg_write(8'h74, 8'(8'h50 + d));
            reg_write(8'h90, 8'(8'h60 + d));
            reg_write(8'h91, 8'(8'h70 + d));
            reg_read(8'h30, "R7 activate readback");
            reg_read(8'h72, "R8 secondary irq");
            reg_read(8'h74, "R8 dma");
            reg_read(8'h90, "R8 mode");
        end
        check_outputs("R7/R8 programmed");
        reg_read(8'h22, "R9 enable map");
        reg_write(8'h22, 8'hFF);
        reg_read(8'h22, "R9 enable map read-only");

        // R10: out-of-range device and unimplemented index
        reg_write(8'h07, 8'd9);
        reg_write(8'h30, 8'h01);
        reg_write(8'h60, 8'hEE);
        reg_read(8'h60, "R10 device 9 reads zero");
        check_outputs("R10 device 9 writes ignored");
        reg_write(8'h07, 8'd2);
        reg_write(8'h45, 8'h99);
        do_read(16'h03F1, "R10 unimplemented index");

        // R11: locked data-port writes ignored
        do_write(16'h03F0, 8'h60);
        do_write(16'h03F0, 8'hAA);
        do_write(16'h03F1, 8'hC3);
        do_read(16'h03F1, "R11 locked read zero");
        check_outputs("R11 locked write ignored");
        unlock();
        do_read(16'h03F1, "R11 register kept");

        random_phase(2500);

        // alternate strap
        apply_reset(1'b1);
        check_outputs("R12 reset alt base");
        do_write(16'h03F0, 8'h55);
        do_write(16'h03F0, 8'h55);
        do_read(16'h0371, "R3 primary base inactive on alt strap");
        unlock();
        reg_read(8'h20, "R3 alternate base opens");
        random_phase(2500);

        done = 1'b1;
        finish_run();
    end

endmodule